// File: doc/BRIEF.md
# Single-Clock FIFO Controller with Rewind

A first-in first-out buffer for 72-bit words on a single clock, with a parameterised power-of-two depth. Two output disciplines are chosen by configuration inputs that are captured only during master reset. In **standard** mode a word reaches the output register only when a read is requested, and the block reports `empty` and `full`. In **fall-through** mode the oldest word is pushed to the output by itself and marked by `out_valid`, and `in_ready` reports free space. `half_full` works in both modes.

The read side can be rewound with `rt_req`, which moves the read pointer back to storage location zero so that the stored stream is delivered again. The write pointer is left alone. The rewind has two latencies, also chosen at master reset. With zero latency the first word is in the output register on the same edge that samples the request. With normal latency it comes one edge later. A partial reset empties the buffer and clears the output register but keeps the captured configuration. A synchronous read select gates the read request and drives an output-enable indicator that models the output pads being driven.

Top module: `fifo_rt_ctrl`

## Requirements
- R1: While `rst_n` is low on a clock edge, the block zeroes both pointers and the output register, clears `rd_oe`, and captures `cfg_fwft` and `cfg_rt_zero`. Directly after reset in standard mode `empty`=1, `full`=0, `half_full`=0 and `rd_data`=0.
- R2: In standard mode `rd_data` changes only on an edge with `rd_en`=1 and `rd_cs`=1, and words come out in the order they were written.
- R3: In fall-through mode a word written into an empty buffer is in `rd_data` with `out_valid`=1 one edge after the write edge, without `rd_en`. Each later word needs an edge with `rd_en`=1 and `rd_cs`=1.
- R4: In standard mode `out_valid` and `in_ready` are held at 0. In fall-through mode `empty` and `full` are held at 0.
- R5: The store holds DEPTH words. At DEPTH words `full` is 1 (standard) and `in_ready` is 0 (fall-through). A write in that state is ignored, and the write pointer does not move.
- R6: A read request while storage is empty is ignored. The read pointer and `rd_data` keep their values.
- R7: `half_full` is 1 exactly when the stored count is greater than DEPTH/2. In fall-through mode the count includes a valid word in the output register.
- R8: With normal latency, `rt_req`=1 on an edge sets the read pointer to 0 and leaves the write pointer unchanged. In standard mode `empty` reads 1 for the one cycle after that edge, and a read on the next edge is ignored. After that the first stored word is read again.
- R9: With zero latency (`cfg_rt_zero`=1 at master reset) and storage written since reset, `rt_req` loads location 0 into `rd_data` on the same edge and sets the read pointer to 1. `empty` is not forced.
- R10: `prst_n`=0 on an edge zeroes both pointers, `rd_data` and `out_valid`, and keeps the captured mode.
- R11: With `rd_cs`=0, `rd_en` has no effect. `rd_oe` equals the `rd_cs` value sampled on the previous edge.
- R12: In fall-through mode with normal latency, `out_valid` is 0 for one cycle after the rewind edge. The next edge presents location 0 with `out_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the write and the read side |
| rst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, synchronous; keeps configuration |
| cfg_fwft | input | 1 | 1 selects fall-through mode; sampled during master reset |
| cfg_rt_zero | input | 1 | 1 selects zero-latency rewind; sampled during master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 72 | Write word |
| rd_en | input | 1 | Read request |
| rd_cs | input | 1 | Synchronous read select, active high |
| rt_req | input | 1 | Rewind request, active high |
| rd_data | output | 72 | Output register |
| rd_oe | output | 1 | Output driven indicator (0 models high impedance) |
| empty | output | 1 | Standard mode: no word available |
| full | output | 1 | Standard mode: store holds DEPTH words |
| out_valid | output | 1 | Fall-through mode: output register holds a word |
| in_ready | output | 1 | Fall-through mode: room for a write |
| half_full | output | 1 | Count greater than DEPTH/2 |

## Verification
The bench drives the buffer to its capacity and writes once more. A design that stored that word would later return it in place of the next expected word. It also reads past empty, where a moving pointer would corrupt `rd_data`. For the rewind it checks the forced-empty cycle and the ignored read on the edge after it. A design without that extra cycle would deliver location 0 one edge early. A design that reset the write pointer on rewind would lose `half_full`. Zero-latency rewind must show location 0 right after the request edge and then location 1. Partial reset must keep fall-through mode, so a design that dropped the configuration would show `empty` instead of `in_ready`.

// File: rtl/fifo_rt_pkg.sv
// Shared constants and types for the rewindable FIFO controller.
// Assumes a single clock domain for all users of these types.
package fifo_rt_pkg;
    localparam int WORD_W = 72;

    typedef logic [WORD_W-1:0] word_t;

    // Configuration captured during master reset.
    typedef struct packed {
        logic fwft;     // fall-through output discipline
        logic rt_zero;  // zero-latency rewind
    } mode_t;
endpackage

// File: rtl/fifo_rt_mem.sv
// Word storage: one synchronous write port, one combinational read port.
// Assumes the caller never writes when full; contents are not reset.
module fifo_rt_mem #(
    parameter int DEPTH  = 16,
    parameter int WIDTH  = 72,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    // Write the addressed location on an accepted write.
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Present the addressed word without a clock.
    assign rdata = store[raddr];
endmodule

// File: rtl/fifo_rt_ptrs.sv
// Write and read pointers, occupancy and rewind pointer handling.
// Assumes DEPTH is a power of two and that a rewind is issued only
// while fewer than DEPTH words have been written since the last reset.
module fifo_rt_ptrs #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              wr_en,
    input  logic              pop,
    input  logic              rt,
    input  logic              rt_zero,
    output logic              wr_fire,
    output logic              rt_load,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W-1:0] raddr,
    output logic [PTR_W-1:0]  wptr,
    output logic [PTR_W-1:0]  rptr,
    output logic [PTR_W-1:0]  count,
    output logic              mem_empty,
    output logic              mem_full
);
    localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);

    assign count     = wptr - rptr;
    assign mem_empty = (count == '0);
    assign mem_full  = (count == FULL_CNT);
    assign wr_fire   = wr_en && !mem_full;
    assign rt_load   = rt && rt_zero && (wptr != '0);
    assign waddr     = wptr[ADDR_W-1:0];
    assign raddr     = rt ? '0 : rptr[ADDR_W-1:0];

    // Advance the write pointer on each accepted write.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            wptr <= '0;
        end else if (wr_fire) begin
            wptr <= wptr + PTR_W'(1);
        end
    end

    // Rewind or advance the read pointer; a rewind wins over a pop.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            rptr <= '0;
        end else if (rt) begin
            rptr <= rt_load ? PTR_W'(1) : '0;
        end else if (pop) begin
            rptr <= rptr + PTR_W'(1);
        end
    end
endmodule

// File: rtl/fifo_rt_out.sv
// Output register, fall-through valid bit, rewind hold and read select.
// Assumes mem_rdata already shows location 0 in a rewind cycle.
module fifo_rt_out #(
    parameter int WIDTH = 72
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             fwft,
    input  logic             rt_zero,
    input  logic             rt,
    input  logic             rt_load,
    input  logic             mem_empty,
    input  logic             rd_en,
    input  logic             rd_cs,
    input  logic [WIDTH-1:0] mem_rdata,
    output logic             pop,
    output logic             hold,
    output logic             ov,
    output logic             oe,
    output logic [WIDTH-1:0] data_q
);
    logic rd_act;

    assign rd_act = rd_en && rd_cs;

    // Decide when a stored word moves into the output register.
    always_comb begin
        if (rt) begin
            pop = 1'b0;
        end else if (fwft) begin
            pop = !mem_empty && (!ov || rd_act);
        end else begin
            pop = rd_act && !mem_empty && !hold;
        end
    end

    // Update the output word, valid bit and rewind hold.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            data_q <= '0;
            ov     <= 1'b0;
            hold   <= 1'b0;
        end else if (rt) begin
            hold <= !fwft && !rt_zero;
            ov   <= fwft && rt_load;
            if (rt_load) begin
                data_q <= mem_rdata;
            end
        end else begin
            hold <= 1'b0;
            if (pop) begin
                data_q <= mem_rdata;
                ov     <= fwft;
            end else if (fwft && rd_act && ov) begin
                ov <= 1'b0;
            end
        end
    end

    // Register the read select as the output-drive indicator.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            oe <= 1'b0;
        end else begin
            oe <= rd_cs;
        end
    end
endmodule

// File: rtl/fifo_rt_ctrl.sv
// Top of the rewindable FIFO controller: captures the configuration at
// master reset and combines pointer state into the mode-dependent flags.
// Assumes one clock for both ports and a power-of-two DEPTH.
module fifo_rt_ctrl #(
    parameter int DEPTH = 16,
    parameter int WIDTH = fifo_rt_pkg::WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prst_n,
    input  logic             cfg_fwft,
    input  logic             cfg_rt_zero,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rd_cs,
    input  logic             rt_req,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_oe,
    output logic             empty,
    output logic             full,
    output logic             out_valid,
    output logic             in_ready,
    output logic             half_full
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;
    localparam int TOT_W  = PTR_W + 1;
    localparam logic [TOT_W-1:0] HALF_CNT = TOT_W'(DEPTH / 2);

    fifo_rt_pkg::mode_t mode_q;
    logic               clr_n;
    logic               wr_fire;
    logic               rt_load;
    logic               pop;
    logic               hold;
    logic               ov;
    logic               mem_empty;
    logic               mem_full;
    logic [ADDR_W-1:0]  waddr;
    logic [ADDR_W-1:0]  raddr;
    logic [PTR_W-1:0]   wptr;
    logic [PTR_W-1:0]   rptr;
    logic [PTR_W-1:0]   count;
    logic [TOT_W-1:0]   total;
    logic [WIDTH-1:0]   mem_rdata;

    assign clr_n = rst_n && prst_n;

    // Capture the configuration while master reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q.fwft    <= cfg_fwft;
            mode_q.rt_zero <= cfg_rt_zero;
        end
    end

    fifo_rt_mem #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH),
        .ADDR_W(ADDR_W)
    ) u_mem (
        .clk  (clk),
        .we   (wr_fire),
        .waddr(waddr),
        .wdata(wr_data),
        .raddr(raddr),
        .rdata(mem_rdata)
    );

    fifo_rt_ptrs #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W),
        .PTR_W (PTR_W)
    ) u_ptrs (
        .clk      (clk),
        .clr_n    (clr_n),
        .wr_en    (wr_en),
        .pop      (pop),
        .rt       (rt_req),
        .rt_zero  (mode_q.rt_zero),
        .wr_fire  (wr_fire),
        .rt_load  (rt_load),
        .waddr    (waddr),
        .raddr    (raddr),
        .wptr     (wptr),
        .rptr     (rptr),
        .count    (count),
        .mem_empty(mem_empty),
        .mem_full (mem_full)
    );

    fifo_rt_out #(
        .WIDTH(WIDTH)
    ) u_out (
        .clk      (clk),
        .clr_n    (clr_n),
        .fwft     (mode_q.fwft),
        .rt_zero  (mode_q.rt_zero),
        .rt       (rt_req),
        .rt_load  (rt_load),
        .mem_empty(mem_empty),
        .rd_en    (rd_en),
        .rd_cs    (rd_cs),
        .mem_rdata(mem_rdata),
        .pop      (pop),
        .hold     (hold),
        .ov       (ov),
        .oe       (rd_oe),
        .data_q   (rd_data)
    );

    // Count words held, including a valid fall-through output word.
    assign total = {1'b0, count} + TOT_W'(mode_q.fwft && ov);

    // Present the flags of the captured mode and hold the others low.
    always_comb begin
        empty     = !mode_q.fwft && (mem_empty || hold);
        full      = !mode_q.fwft && mem_full;
        out_valid = mode_q.fwft && ov;
        in_ready  = mode_q.fwft && !mem_full;
        half_full = total > HALF_CNT;
    end
endmodule

// File: rtl/fifo_rt_ctrl_chk.sv
// Checker for the rewindable FIFO controller, attached through bind.
// Observes ports and pointer state; drives nothing.
module fifo_rt_ctrl_chk #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 72,
    parameter int PTR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prst_n,
    input logic             wr_en,
    input logic             rd_cs,
    input logic             rt_req,
    input logic             mode_fwft,
    input logic             mode_rt_zero,
    input logic             empty,
    input logic             full,
    input logic             out_valid,
    input logic             in_ready,
    input logic [WIDTH-1:0] rd_data,
    input logic [PTR_W-1:0] wptr,
    input logic [PTR_W-1:0] rptr
);
    localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);

    assert_mode_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_fwft |-> (!empty && !full));
    assert_std_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_fwft |-> (!out_valid && !in_ready));
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_n && wr_en && (wptr - rptr == FULL_CNT)) |=> (wptr == $past(wptr)));
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_n && !rt_req && (wptr == rptr)) |=> (rptr == $past(rptr)));
    assert_rewind_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_n && rt_req && !mode_rt_zero) |=> (rptr == '0));
    assert_rewind_keeps_wptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_n && rt_req && !wr_en) |=> (wptr == $past(wptr)));
    assert_rewind_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_n && rt_req && mode_rt_zero && (wptr != '0)) |=> (rptr == PTR_W'(1)));
    assert_partial_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !prst_n |=> (rd_data == '0 && !out_valid && rptr == '0 && wptr == '0));
    assert_partial_keeps_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !prst_n |=> (mode_fwft == $past(mode_fwft) && mode_rt_zero == $past(mode_rt_zero)));
    assert_cs_gates_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_n && !rd_cs && !rt_req && !mode_fwft) |=> (rptr == $past(rptr)));
endmodule

bind fifo_rt_ctrl fifo_rt_ctrl_chk #(
    .DEPTH(DEPTH),
    .WIDTH(WIDTH),
    .PTR_W(PTR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prst_n      (prst_n),
    .wr_en       (wr_en),
    .rd_cs       (rd_cs),
    .rt_req      (rt_req),
    .mode_fwft   (mode_q.fwft),
    .mode_rt_zero(mode_q.rt_zero),
    .empty       (empty),
    .full        (full),
    .out_valid   (out_valid),
    .in_ready    (in_ready),
    .rd_data     (rd_data),
    .wptr        (wptr),
    .rptr        (rptr)
);

// File: tb/fifo_rt_ctrl_bench.sv
// Self-checking bench: a vector table in standard mode, then directed
// tests for reset, rewind latencies, read select and fall-through mode.
module fifo_rt_ctrl_bench;
    localparam int DEPTH = 4;
    localparam int W     = 72;
    localparam int NVEC  = 13;

    // Vector fields: wr, rd, write byte, exp empty, exp full, exp half, exp data byte.
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 8'hA1, 1'b0, 1'b0, 1'b0, 8'h00},  // R2 no output yet
        {1'b1, 1'b0, 8'hA2, 1'b0, 1'b0, 1'b0, 8'h00},
        {1'b1, 1'b0, 8'hA3, 1'b0, 1'b0, 1'b1, 8'h00},  // R7 count 3
        {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'hA1},  // R2 first word
        {1'b1, 1'b1, 8'hA4, 1'b0, 1'b0, 1'b0, 8'hA2},
        {1'b1, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b1, 8'hA2},
        {1'b1, 1'b0, 8'hA6, 1'b0, 1'b1, 1'b1, 8'hA2},  // R5 full
        {1'b1, 1'b0, 8'hA7, 1'b0, 1'b1, 1'b1, 8'hA2},  // R5 write ignored
        {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'hA3},
        {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'hA4},
        {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'hA5},
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 8'hA6},  // R5 A7 never stored
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 8'hA6}   // R6 read on empty
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         prst_n = 1'b1;
    logic         cfg_fwft = 1'b0;
    logic         cfg_rt_zero = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic         rd_cs = 1'b1;
    logic         rt_req = 1'b0;
    logic [W-1:0] rd_data;
    logic         rd_oe;
    logic         empty;
    logic         full;
    logic         out_valid;
    logic         in_ready;
    logic         half_full;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    fifo_rt_ctrl #(.DEPTH(DEPTH)) u_fifo_rt_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .prst_n     (prst_n),
        .cfg_fwft   (cfg_fwft),
        .cfg_rt_zero(cfg_rt_zero),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_cs      (rd_cs),
        .rt_req     (rt_req),
        .rd_data    (rd_data),
        .rd_oe      (rd_oe),
        .empty      (empty),
        .full       (full),
        .out_valid  (out_valid),
        .in_ready   (in_ready),
        .half_full  (half_full)
    );

    function automatic logic [W-1:0] word(input logic [7:0] b);
        return {9{b}};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic master_reset(input logic fwft, input logic rtz);
        cfg_fwft    = fwft;
        cfg_rt_zero = rtz;
        wr_en = 1'b0; rd_en = 1'b0; rt_req = 1'b0; prst_n = 1'b1;
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic put(input logic [7:0] b);
        wr_en = 1'b1; wr_data = word(b);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic get();
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        // R1 reset state in standard mode
        master_reset(1'b0, 1'b0);
        chk("R1 empty", W'(empty), W'(1));
        chk("R1 full", W'(full), W'(0));
        chk("R1 half_full", W'(half_full), W'(0));
        chk("R1 rd_data", rd_data, '0);
        chk("R1 rd_oe", W'(rd_oe), W'(0));
        chk("R4 std out_valid/in_ready", W'({out_valid, in_ready}), W'(0));
        tick();
        chk("R11 rd_oe follows rd_cs", W'(rd_oe), W'(1));

        // Vector table walk (R2 R5 R6 R7)
        for (int i = 0; i < NVEC; i++) begin
            wr_en   = VEC[i][20];
            rd_en   = VEC[i][19];
            wr_data = word(VEC[i][18:11]);
            tick();
            chk($sformatf("R2/R5/R6 vec%0d empty", i), W'(empty), W'(VEC[i][10]));
            chk($sformatf("R5 vec%0d full", i), W'(full), W'(VEC[i][9]));
            chk($sformatf("R7 vec%0d half_full", i), W'(half_full), W'(VEC[i][8]));
            chk($sformatf("R2 vec%0d rd_data", i), rd_data, word(VEC[i][7:0]));
        end
        wr_en = 1'b0; rd_en = 1'b0;

        // R8 normal-latency rewind in standard mode
        master_reset(1'b0, 1'b0);
        put(8'hB0); put(8'hB1); put(8'hB2);
        get();
        chk("R2 first read", rd_data, word(8'hB0));
        rt_req = 1'b1; tick(); rt_req = 1'b0;
        chk("R8 empty forced after rewind", W'(empty), W'(1));
        chk("R8 write pointer kept (half_full)", W'(half_full), W'(1));
        get();
        chk("R8 read in hold cycle ignored", rd_data, word(8'hB0));
        chk("R8 empty released", W'(empty), W'(0));
        get();
        chk("R8 first word again", rd_data, word(8'hB0));
        get();
        chk("R8 second word again", rd_data, word(8'hB1));

        // R9 zero-latency rewind and R11 read select
        master_reset(1'b0, 1'b1);
        put(8'hC0); put(8'hC1); put(8'hC2);
        get(); get();
        chk("R2 order", rd_data, word(8'hC1));
        rd_cs = 1'b0; rd_en = 1'b1; tick(); rd_en = 1'b0;
        chk("R11 read ignored with cs low", rd_data, word(8'hC1));
        chk("R11 rd_oe low", W'(rd_oe), W'(0));
        rd_cs = 1'b1; tick();
        chk("R11 rd_oe back high", W'(rd_oe), W'(1));
        rt_req = 1'b1; tick(); rt_req = 1'b0;
        chk("R9 location 0 on rewind edge", rd_data, word(8'hC0));
        chk("R9 empty not forced", W'(empty), W'(0));
        get();
        chk("R9 next word is location 1", rd_data, word(8'hC1));

        // R3 R4 R5 R7 fall-through mode
        master_reset(1'b1, 1'b0);
        chk("R4 fwft empty/full low", W'({empty, full}), W'(0));
        chk("R4 fwft in_ready", W'(in_ready), W'(1));
        chk("R4 fwft out_valid", W'(out_valid), W'(0));
        put(8'hD0);
        chk("R3 not yet valid on write edge", W'(out_valid), W'(0));
        tick();
        chk("R3 falls through", W'(out_valid), W'(1));
        chk("R3 first word", rd_data, word(8'hD0));
        put(8'hD1); put(8'hD2); put(8'hD3); put(8'hD4);
        chk("R3 held without rd_en", rd_data, word(8'hD0));
        chk("R5 in_ready low at capacity", W'(in_ready), W'(0));
        chk("R7 half_full counts output word", W'(half_full), W'(1));
        get();
        chk("R3 next word on read", rd_data, word(8'hD1));
        chk("R5 in_ready back", W'(in_ready), W'(1));

        // R10 partial reset keeps fall-through mode
        prst_n = 1'b0; tick(); prst_n = 1'b1;
        chk("R10 rd_data cleared", rd_data, '0);
        chk("R10 out_valid cleared", W'(out_valid), W'(0));
        chk("R10 mode kept (in_ready)", W'(in_ready), W'(1));
        chk("R10 mode kept (empty low)", W'(empty), W'(0));

        // R12 normal-latency rewind in fall-through mode
        put(8'hF0); put(8'hF1); tick();
        chk("R3 after partial reset", rd_data, word(8'hF0));
        get();
        chk("R3 second word", rd_data, word(8'hF1));
        rt_req = 1'b1; tick(); rt_req = 1'b0;
        chk("R12 out_valid low after rewind", W'(out_valid), W'(0));
        tick();
        chk("R12 out_valid back", W'(out_valid), W'(1));
        chk("R12 location 0 presented", rd_data, word(8'hF0));

        // R1 master reset clears output and recaptures mode
        master_reset(1'b0, 1'b0);
        chk("R1 rd_data zero after master reset", rd_data, '0);
        chk("R1 standard mode recaptured", W'(empty), W'(1));

        finished = 1'b1;
        finish_run();
    end
endmodule